// File: doc/BRIEF.md
# Low Battery Gain Reduction Controller

This controller lowers the gain of an audio path as a battery weakens. Its inputs are threshold comparator flags for two views of the supply. The instantaneous view is compared at roughly 0.95 V, 1.0 V and 1.1 V. The averaged view is compared at 0.95 V and 1.1 V. A one-cycle pulse arrives once per second. The controller returns a total attenuation in dB, which the gain stage applies, and a mute flag.

Two reduction loops run side by side and do not share state. The dip loop handles short sags of the instantaneous supply. It reacts at once in coarse 3 dB steps, then waits through a hold-off period. It gives the steps back only after the supply has stayed healthy for a whole monitoring window. The average loop tracks sustained depletion. It steps 1 dB at a time on a slower ramp and mutes the audio once its count is full. When the averaged supply recovers, it unmutes first and then ramps the gain back up. All periods are counted in ticks of the one-second pulse and are set by parameters.

Top module: `lowbat_gain_ctrl`

## Requirements
- R1: When `avg_gt_lo_i` is 1, no hold-off is running and `inst_gt_lo_i` is 0, the dip count rises by one on the next clock edge, with no wait for a tick. The count stops at INST_MAX. It never rises while `avg_gt_lo_i` is 0.
- R2: Each dip step starts a hold-off of HOLD_TICKS ticks. During the hold-off no further dip step is taken and no recovery window counts.
- R3: When `inst_gt_hi_i` stays 1 through WIN_TICKS consecutive ticks, the dip count returns to 0 at the last of those ticks. This applies only after the hold-off has ended and while the dip count is non-zero.
- R4: When the dip count equals INST_MAX and `inst_gt_mid_i` stays 1 through WIN_TICKS consecutive ticks, the count drops by exactly one. This window has no effect at lower counts.
- R5: A recovery window restarts from zero if its flag goes to 0 for even one cycle.
- R6: While `avg_gt_lo_i` is 0, the average count rises by one every AVG_TICKS ticks, up to AVG_MAX. The step that reaches AVG_MAX also sets `mute_o`.
- R7: While `avg_gt_hi_i` is 1 and the block is muted, the next edge clears `mute_o` and leaves the count as it is. After that, the average count falls by one every AVG_TICKS ticks, down to 0.
- R8: In the middle band (`avg_gt_lo_i`=1, `avg_gt_hi_i`=0) the average loop does nothing. Any change of band restarts the AVG_TICKS period.
- R9: `atten_db_o` equals INST_STEP_DB times the dip count plus the average count. The two counts are independent.
- R10: After reset, `atten_db_o` is 0 and `mute_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| inst_gt_lo_i | input | 1 | Instantaneous supply above 0.95 V |
| inst_gt_mid_i | input | 1 | Instantaneous supply above 1.0 V |
| inst_gt_hi_i | input | 1 | Instantaneous supply above 1.1 V |
| avg_gt_lo_i | input | 1 | Averaged supply above 0.95 V |
| avg_gt_hi_i | input | 1 | Averaged supply above 1.1 V |
| atten_db_o | output | ATTEN_W | Total attenuation in dB |
| mute_o | output | 1 | Audio muted |

## Verification
The bench uses short periods and sweeps each loop through its steps one tick at a time. At each step it compares the output against a count worked out from the requirements.

The dip loop is tried with several patterns, each aimed at one rule:
- a held dip, which separates an immediate step from one deferred to the hold-off;
- a third dip at full count, which shows the step limit;
- a mid-level recovery, which shows that it only undoes one step from the top;
- a high-level window broken for one cycle, which must delay the recovery by a full window.

The average loop is tried with:
- a long low band, which shows the ramp limit and when mute is set;
- a stay in the middle band, which must change nothing;
- a high band, which shows that unmute comes before any gain is restored;
- a high period broken by a brief middle-band visit, which shows that the period restarts.

A dip taken while the averaged supply is low must have no effect. A dip taken while the average count is non-zero shows that the output is the sum of the two loops.

// File: rtl/lbg_pkg.sv
package lbg_pkg;

  typedef enum logic [1:0] {
    BAND_MID = 2'd0,
    BAND_LO  = 2'd1,
    BAND_HI  = 2'd2
  } avg_band_e;

  function automatic avg_band_e band_of(input logic gt_lo, input logic gt_hi);
    if (!gt_lo)     return BAND_LO;
    else if (gt_hi) return BAND_HI;
    else            return BAND_MID;
  endfunction

endpackage

// File: rtl/lbg_period_cnt.sv
module lbg_period_cnt #(
  parameter int unsigned PERIOD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last   = (cnt_q == CW'(PERIOD - 1));
  assign done_o = tick_i && !clr_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lbg_inst_loop.sv
module lbg_inst_loop #(
  parameter int unsigned INST_MAX   = 2,
  parameter int unsigned HOLD_TICKS = 30,
  parameter int unsigned WIN_TICKS  = 30,
  localparam int unsigned IW = $clog2(INST_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          avg_ok_i,
  input  logic          lo_i,
  input  logic          mid_i,
  input  logic          hi_i,
  output logic [IW-1:0] cnt_o
);
  logic [IW-1:0] cnt_q;
  logic          hold_q, hold_done, dip;
  logic [1:0]    win_ok, win_done;

  assign dip    = avg_ok_i && !lo_i && !hold_q && (cnt_q < IW'(INST_MAX));
  assign win_ok = {hi_i, mid_i};

  lbg_period_cnt #(.PERIOD(HOLD_TICKS)) u_hold (
    .clk_i, .rst_ni, .clr_i(!hold_q), .tick_i, .done_o(hold_done)
  );

  // [0]: partial recovery window, [1]: full recovery window
  for (genvar g = 0; g < 2; g++) begin : g_win
    lbg_period_cnt #(.PERIOD(WIN_TICKS)) u_win (
      .clk_i, .rst_ni,
      .clr_i (hold_q || (cnt_q == '0) || !win_ok[g]),
      .tick_i,
      .done_o(win_done[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else if (dip) begin
      cnt_q  <= cnt_q + 1'b1;
      hold_q <= 1'b1;
    end else begin
      if (hold_done) hold_q <= 1'b0;
      if (win_done[1])                              cnt_q <= '0;
      else if (win_done[0] && cnt_q == IW'(INST_MAX)) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/lbg_avg_loop.sv
module lbg_avg_loop
  import lbg_pkg::*;
#(
  parameter int unsigned AVG_MAX   = 18,
  parameter int unsigned AVG_TICKS = 10,
  localparam int unsigned AW = $clog2(AVG_MAX + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          gt_lo_i,
  input  logic          gt_hi_i,
  output logic [AW-1:0] cnt_o,
  output logic          mute_o
);
  avg_band_e     band_d, band_q;
  logic [AW-1:0] cnt_q;
  logic          mute_q, clr, done, unmute;

  assign band_d = band_of(gt_lo_i, gt_hi_i);
  assign unmute = mute_q && (band_d == BAND_HI);
  assign clr    = (band_d != band_q) || (band_d == BAND_MID) || unmute;

  lbg_period_cnt #(.PERIOD(AVG_TICKS)) u_ramp (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i, .done_o(done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      band_q <= BAND_MID;
      cnt_q  <= '0;
      mute_q <= 1'b0;
    end else begin
      band_q <= band_d;
      if (unmute) begin
        mute_q <= 1'b0;
      end else if (done) begin
        if (band_d == BAND_LO && cnt_q < AW'(AVG_MAX)) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == AW'(AVG_MAX - 1)) mute_q <= 1'b1;
        end else if (band_d == BAND_HI && cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign mute_o = mute_q;
endmodule

// File: rtl/lowbat_gain_ctrl.sv
module lowbat_gain_ctrl #(
  parameter int unsigned INST_STEP_DB = 3,
  parameter int unsigned INST_MAX     = 2,
  parameter int unsigned AVG_MAX      = 18,
  parameter int unsigned HOLD_TICKS   = 30,
  parameter int unsigned WIN_TICKS    = 30,
  parameter int unsigned AVG_TICKS    = 10,
  localparam int unsigned ATTEN_W = $clog2(INST_STEP_DB * INST_MAX + AVG_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               inst_gt_lo_i,
  input  logic               inst_gt_mid_i,
  input  logic               inst_gt_hi_i,
  input  logic               avg_gt_lo_i,
  input  logic               avg_gt_hi_i,
  output logic [ATTEN_W-1:0] atten_db_o,
  output logic               mute_o
);
  localparam int unsigned IW = $clog2(INST_MAX + 1);
  localparam int unsigned AW = $clog2(AVG_MAX + 1);

  logic [IW-1:0] inst_cnt;
  logic [AW-1:0] avg_cnt;

  lbg_inst_loop #(
    .INST_MAX(INST_MAX), .HOLD_TICKS(HOLD_TICKS), .WIN_TICKS(WIN_TICKS)
  ) u_inst (
    .clk_i, .rst_ni, .tick_i,
    .avg_ok_i(avg_gt_lo_i),
    .lo_i    (inst_gt_lo_i),
    .mid_i   (inst_gt_mid_i),
    .hi_i    (inst_gt_hi_i),
    .cnt_o   (inst_cnt)
  );

  lbg_avg_loop #(.AVG_MAX(AVG_MAX), .AVG_TICKS(AVG_TICKS)) u_avg (
    .clk_i, .rst_ni, .tick_i,
    .gt_lo_i(avg_gt_lo_i),
    .gt_hi_i(avg_gt_hi_i),
    .cnt_o  (avg_cnt),
    .mute_o (mute_o)
  );

  assign atten_db_o = ATTEN_W'(inst_cnt) * ATTEN_W'(INST_STEP_DB) + ATTEN_W'(avg_cnt);
endmodule

// File: rtl/lbg_chk.sv
module lbg_chk #(
  parameter int unsigned INST_MAX = 2,
  parameter int unsigned AVG_MAX  = 18,
  localparam int unsigned IW = $clog2(INST_MAX + 1),
  localparam int unsigned AW = $clog2(AVG_MAX + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inst_gt_lo_i,
  input logic          avg_gt_lo_i,
  input logic          avg_gt_hi_i,
  input logic [IW-1:0] inst_cnt,
  input logic [AW-1:0] avg_cnt,
  input logic          mute_o
);
  // R1
  dip_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_cnt > $past(inst_cnt)) |-> ($past(avg_gt_lo_i) && !$past(inst_gt_lo_i)));

  // R2
  dip_holdoff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_cnt > $past(inst_cnt)) |=> (inst_cnt <= $past(inst_cnt)));

  // R6
  mute_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mute_o) |-> (avg_cnt == AW'(AVG_MAX)));

  // R7
  unmute_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> ($past(avg_gt_hi_i) && $stable(avg_cnt)));

  // R7
  restore_unmuted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_cnt < $past(avg_cnt)) |-> ($past(avg_gt_hi_i) && !$past(mute_o)));

  // R8
  mid_band_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (avg_cnt != $past(avg_cnt)) |-> !($past(avg_gt_lo_i) && !$past(avg_gt_hi_i)));
endmodule

bind lowbat_gain_ctrl lbg_chk #(.INST_MAX(INST_MAX), .AVG_MAX(AVG_MAX)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .inst_gt_lo_i (inst_gt_lo_i),
  .avg_gt_lo_i  (avg_gt_lo_i),
  .avg_gt_hi_i  (avg_gt_hi_i),
  .inst_cnt     (inst_cnt),
  .avg_cnt      (avg_cnt),
  .mute_o       (mute_o)
);

// File: tb/lowbat_gain_ctrl_tb.sv
module lowbat_gain_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 3, IMAX = 2, AMAX = 5, HOLD = 4, WIN = 4, AVGT = 3;
  localparam int AT_W = $clog2(STEP * IMAX + AMAX + 1);

  logic clk = 1'b0, rst_ni = 1'b0, tick = 1'b0;
  logic i_lo = 1'b1, i_mid = 1'b1, i_hi = 1'b1, a_lo = 1'b1, a_hi = 1'b0;
  logic [AT_W-1:0] atten;
  logic mute;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lowbat_gain_ctrl #(
    .INST_STEP_DB(STEP), .INST_MAX(IMAX), .AVG_MAX(AMAX),
    .HOLD_TICKS(HOLD), .WIN_TICKS(WIN), .AVG_TICKS(AVGT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .inst_gt_lo_i(i_lo), .inst_gt_mid_i(i_mid), .inst_gt_hi_i(i_hi),
    .avg_gt_lo_i(a_lo), .avg_gt_hi_i(a_hi),
    .atten_db_o(atten), .mute_o(mute)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // level: 0 <0.95, 1 0.95..1.0, 2 1.0..1.1, 3 >1.1
  task automatic set_inst(input int lvl);
    i_lo = (lvl >= 1); i_mid = (lvl >= 2); i_hi = (lvl >= 3);
  endtask

  // band: 0 low, 1 middle, 2 high
  task automatic set_avg(input int b);
    a_lo = (b >= 1); a_hi = (b >= 2);
  endtask

  task automatic chk(input string req, input int inst_n, input int avg_n, input bit m);
    int exp_at;
    exp_at = STEP * inst_n + avg_n;
    n_vec++;
    if (int'(atten) != exp_at || mute != m) begin
      n_bad++;
      $display("FAIL %s: atten=%0d mute=%0b expected atten=%0d mute=%0b",
               req, atten, mute, exp_at, m);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    report();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    chk("R10 reset", 0, 0, 0);

    // dip loop, average in middle band
    set_inst(0); cyc(1);      chk("R1 immediate dip", 1, 0, 0);
    cyc(3);                   chk("R2 no step in hold-off", 1, 0, 0);
    ticks(HOLD - 1);          chk("R2 hold-off not yet over", 1, 0, 0);
    ticks(1); cyc(1);         chk("R2 step after hold-off", 2, 0, 0);
    ticks(HOLD); cyc(2);      chk("R1 cap at INST_MAX", 2, 0, 0);
    set_inst(2); ticks(WIN - 1); chk("R4 window incomplete", 2, 0, 0);
    ticks(1);                 chk("R4 one step back", 1, 0, 0);
    ticks(WIN);               chk("R4 no effect below max", 1, 0, 0);
    set_inst(3); ticks(WIN - 1); chk("R3 window incomplete", 1, 0, 0);
    set_inst(2); cyc(1); set_inst(3);
    ticks(WIN - 1);           chk("R5 broken window restarted", 1, 0, 0);
    ticks(1);                 chk("R3 full recovery", 0, 0, 0);

    // average loop
    set_avg(0); ticks(AVGT - 1); chk("R6 period incomplete", 0, 0, 0);
    ticks(1);                 chk("R6 first step", 0, 1, 0);
    set_inst(0); cyc(2);      chk("R1 dip ignored in low average", 0, 1, 0);
    set_inst(3);
    ticks(3 * AVGT);          chk("R6 ramp before full", 0, 4, 0);
    ticks(AVGT);              chk("R6 mute on last step", 0, 5, 1);
    ticks(AVGT);              chk("R6 cap at AVG_MAX", 0, 5, 1);
    set_avg(1); ticks(2 * AVGT); chk("R8 middle band idle", 0, 5, 1);
    set_inst(0); cyc(2);      chk("R9 sum of both loops", 1, 5, 1);
    set_inst(3); ticks(HOLD + WIN - 1); chk("R9 dip held, average idle", 1, 5, 1);
    ticks(1);                 chk("R3 recovery with average held", 0, 5, 1);
    set_avg(2); cyc(1);       chk("R7 unmute first", 0, 5, 0);
    ticks(AVGT - 1);          chk("R7 period incomplete", 0, 5, 0);
    ticks(1);                 chk("R7 first restore", 0, 4, 0);
    ticks(2); set_avg(1); cyc(1); set_avg(2);
    ticks(2);                 chk("R8 band change restarts period", 0, 4, 0);
    ticks(1);                 chk("R7 restore after restart", 0, 3, 0);
    ticks(3 * AVGT);          chk("R7 restored to zero", 0, 0, 0);
    ticks(AVGT);              chk("R7 floor at zero", 0, 0, 0);
    report();
  end
endmodule